// File: doc/BRIEF.md
# Color palette host access controller

This block is the host-side register port of a 256-entry color lookup table. Each entry holds three 6-bit components. A byte-wide host bus uses a 3-bit register select and single-cycle read and write strobes. Through it the host sets a palette pointer, moves color entries one component at a time, programs a pixel mask and programs a mode (command) register. The palette storage sits inside the block as a behavioural array, and the block owns its only port.

To load colors, the host writes a start index to the write-mode pointer. It then streams red, green and blue bytes to the color-data select. Each completed triple is stored and the pointer steps on. To read colors back, the host writes an index to the read-mode pointer. The block fetches that entry into a holding register at once and steps the pointer. Three byte reads then drain the holding register, and the third read refetches from the next index. Loading the pointer by either select abandons any half-finished triple.

Some hosts cannot drive the top select bit. For them, four back-to-back reads of the mask select arm a one-shot redirect, so the next access at the mask select reaches the mode register instead. Accesses at the clock-generator selects are passed out as strobes, with read data taken from an input. If a cycle carries both strobes, the write is performed and the read is dropped.

Top module: `palette_host_ctrl`

## Requirements
- R1: After reset the pointer reads 0x00, the mode register `cmd_mode` is 0x00 (palette mode), `pix_mask` is 0xFF and `host_rdata` is 0x00.
- R2: Reading select 3'b000 and reading select 3'b011 both return the same 8-bit pointer value.
- R3: Color bytes travel in the order red, green, blue. A write stores only data bits 5:0, and a read returns the component in bits 5:0 with bits 7:6 at zero.
- R4: The third (blue) write to select 3'b001 stores {red, green, blue} at the pointer, and the pointer then increments.
- R5: A write to select 3'b011 loads the pointer with data+1 and fetches entry `data` into the holding register. After each third (blue) read, the entry at the pointer is fetched and the pointer increments again.
- R6: A write to select 3'b000 or 3'b011 abandons any partial color transfer, so the next color byte is red again.
- R7: After four consecutive reads of select 3'b010, the next read or write at 3'b010 accesses the mode register, and the mask register is not changed.
- R8: The redirect is used up by one access, and any access to another select clears both the redirect and the count of consecutive mask reads.
- R9: Select 3'b110 reads and writes the mode register directly, and `cmd_mode` shows its value on the cycle after the write.
- R10: Selects 3'b100 and 3'b111 (clock index) and 3'b101 (clock parameter) raise `pll_wr` or `pll_rd` in the same cycle, with `pll_param` high only for 3'b101. A read at these selects returns `pll_rdata`, and these accesses leave the palette state unchanged.
- R11: The pointer wraps from 0xFF to 0x00 on increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_sel | input | 3 | Register select, sampled with a strobe |
| host_wr | input | 1 | Single-cycle write strobe |
| host_rd | input | 1 | Single-cycle read strobe |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, valid the cycle after a read strobe |
| pll_rdata | input | 8 | Read data from the clock-generator registers |
| pll_wr | output | 1 | Write strobe forwarded to the clock-generator registers |
| pll_rd | output | 1 | Read strobe forwarded to the clock-generator registers |
| pll_param | output | 1 | 1 = parameter select, 0 = index select |
| cmd_mode | output | 8 | Current mode register value |
| pix_mask | output | 8 | Current pixel mask value |

## Verification
The blue read of a triple does two things at the same clock edge: it returns the old entry's blue byte, and it refetches the holding register from the pointer while the pointer increments. The bench reads three consecutive entries back to back, so each refetch lands on the same edge as a returned byte. It judges this by checking that each byte belongs to the expected entry and that the pointer afterwards sits one past the last entry. A second overlap happens when a pointer load arrives partway through a triple, so the abort and the new load occur on one edge. The bench provokes this both mid-write and mid-read, and then checks that the stored and returned data start again at red.

// File: rtl/palette_host_pkg.sv
// Package: shared select codes, byte-slot encoding and decoded access flags
// for the palette host access controller.
package palette_host_pkg;

    // Register select codes; the redirect path depends on SEL_MASK.
    typedef enum logic [2:0] {
        SEL_PTR_WR    = 3'b000,
        SEL_COLOR     = 3'b001,
        SEL_MASK      = 3'b010,
        SEL_PTR_RD    = 3'b011,
        SEL_CLK_WIDX  = 3'b100,
        SEL_CLK_PARAM = 3'b101,
        SEL_MODE      = 3'b110,
        SEL_CLK_RIDX  = 3'b111
    } reg_sel_e;

    // Position inside a three-byte color transfer.
    typedef enum logic [1:0] {
        SLOT_RED   = 2'd0,
        SLOT_GREEN = 2'd1,
        SLOT_BLUE  = 2'd2
    } byte_slot_e;

    // One-hot style decoded accesses for the current cycle.
    typedef struct packed {
        logic ptr_load_w;
        logic ptr_load_r;
        logic ptr_read;
        logic color_wr;
        logic color_rd;
        logic mask_wr;
        logic mask_rd;
        logic mode_wr;
        logic mode_rd;
        logic clk_wr;
        logic clk_rd;
        logic clk_param;
    } host_hits_t;

endpackage

// File: rtl/palette_ram.sv
// Module: palette_ram
// Behavioural color lookup storage with one write port and a combinational
// read port. It assumes a single owner, so there is no arbitration, and the
// contents are not reset.
module palette_ram #(
    parameter int ADDR_W = 8,
    parameter int WORD_W = 18
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [WORD_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] mem [DEPTH];

    // Store a word on a write enable.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Combinational read, used by the prefetch.
    assign rdata = mem[raddr];

endmodule

// File: rtl/palette_hidden_flag.sv
// Module: palette_hidden_flag
// Counts back-to-back reads of the mask select. When the count reaches
// ARM_COUNT, the next mask-select access is redirected to the mode register,
// and that access clears the count. Any access at another select, or a mask
// write while not armed, also clears the count. It assumes at most one
// effective strobe per cycle.
module palette_hidden_flag
    import palette_host_pkg::*;
#(
    parameter int ARM_COUNT = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] host_sel,
    input  logic       acc_wr,
    input  logic       acc_rd,
    output logic       armed
);
    localparam int CNT_W = $clog2(ARM_COUNT + 1);
    localparam logic [CNT_W-1:0] CNT_ARM = CNT_W'(ARM_COUNT);

    logic [CNT_W-1:0] rd_count;
    logic             at_mask;

    assign at_mask = (host_sel == SEL_MASK);
    assign armed   = (rd_count == CNT_ARM);

    // Track consecutive mask reads and consume the redirect.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_count <= '0;
        end else if (acc_wr || acc_rd) begin
            if (!at_mask || armed || acc_wr) begin
                rd_count <= '0;
            end else begin
                rd_count <= rd_count + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/palette_sel_decode.sv
// Module: palette_sel_decode
// Turns the select code and strobes into per-register access flags. The
// redirect flag steers a mask-select access to the mode register. A write
// takes priority, so a read in the same cycle as a write is dropped.
module palette_sel_decode
    import palette_host_pkg::*;
(
    input  logic       host_wr,
    input  logic       host_rd,
    input  logic [2:0] host_sel,
    input  logic       redirect,
    output logic       eff_wr,
    output logic       eff_rd,
    output host_hits_t hits
);
    assign eff_wr = host_wr;
    assign eff_rd = host_rd && !host_wr;

    // Decode one access per cycle.
    always_comb begin
        hits = '0;
        unique case (host_sel)
            SEL_PTR_WR: begin
                hits.ptr_load_w = eff_wr;
                hits.ptr_read   = eff_rd;
            end
            SEL_PTR_RD: begin
                hits.ptr_load_r = eff_wr;
                hits.ptr_read   = eff_rd;
            end
            SEL_COLOR: begin
                hits.color_wr = eff_wr;
                hits.color_rd = eff_rd;
            end
            SEL_MASK: begin
                hits.mask_wr = eff_wr && !redirect;
                hits.mask_rd = eff_rd && !redirect;
                hits.mode_wr = eff_wr && redirect;
                hits.mode_rd = eff_rd && redirect;
            end
            SEL_MODE: begin
                hits.mode_wr = eff_wr;
                hits.mode_rd = eff_rd;
            end
            SEL_CLK_PARAM: begin
                hits.clk_wr    = eff_wr;
                hits.clk_rd    = eff_rd;
                hits.clk_param = 1'b1;
            end
            default: begin
                hits.clk_wr = eff_wr;
                hits.clk_rd = eff_rd;
            end
        endcase
    end

endmodule

// File: rtl/palette_rgb_seq.sv
// Module: palette_rgb_seq
// Owns the palette pointer, the byte slot and the color holding registers.
// It gathers write triples and commits them, prefetches entries for read-back
// and drops a partial triple whenever the pointer is loaded. It assumes the
// decoded access flags are mutually exclusive.
module palette_rgb_seq
    import palette_host_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 8,
    parameter int COMP_W = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ptr_load_w,
    input  logic                ptr_load_r,
    input  logic                color_wr,
    input  logic                color_rd,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [3*COMP_W-1:0] ram_rdata,
    output logic                ram_we,
    output logic [ADDR_W-1:0]   ram_waddr,
    output logic [3*COMP_W-1:0] ram_wdata,
    output logic [ADDR_W-1:0]   ram_raddr,
    output logic [ADDR_W-1:0]   pix_addr,
    output byte_slot_e          byte_slot,
    output logic [COMP_W-1:0]   rd_comp
);
    localparam int NCOMP = 3;

    logic [COMP_W-1:0]        stage_red;
    logic [COMP_W-1:0]        stage_green;
    logic [NCOMP*COMP_W-1:0]  hold_q;
    logic [COMP_W-1:0]        comp [NCOMP];
    logic [ADDR_W-1:0]        wd_addr;
    logic [COMP_W-1:0]        wd_comp;
    logic [ADDR_W-1:0]        ptr_next;

    assign wd_addr  = wdata[ADDR_W-1:0];
    assign wd_comp  = wdata[COMP_W-1:0];
    assign ptr_next = pix_addr + ADDR_W'(1);

    // Split the holding register into components, red in the top field.
    for (genvar gi = 0; gi < NCOMP; gi++) begin : g_comp
        assign comp[gi] = hold_q[(NCOMP-gi)*COMP_W-1 -: COMP_W];
    end

    // Return the component the current slot points at.
    always_comb begin
        unique case (byte_slot)
            SLOT_GREEN: rd_comp = comp[1];
            SLOT_BLUE:  rd_comp = comp[2];
            default:    rd_comp = comp[0];
        endcase
    end

    // The prefetch reads the index being written, otherwise the pointer.
    assign ram_raddr = ptr_load_r ? wd_addr : pix_addr;
    assign ram_we    = color_wr && (byte_slot == SLOT_BLUE);
    assign ram_waddr = pix_addr;
    assign ram_wdata = {stage_red, stage_green, wd_comp};

    // Pointer, slot and holding-register sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_addr    <= '0;
            byte_slot   <= SLOT_RED;
            stage_red   <= '0;
            stage_green <= '0;
            hold_q      <= '0;
        end else if (ptr_load_w) begin
            pix_addr  <= wd_addr;
            byte_slot <= SLOT_RED;
        end else if (ptr_load_r) begin
            hold_q    <= ram_rdata;
            pix_addr  <= wd_addr + ADDR_W'(1);
            byte_slot <= SLOT_RED;
        end else if (color_wr) begin
            unique case (byte_slot)
                SLOT_RED: begin
                    stage_red <= wd_comp;
                    byte_slot <= SLOT_GREEN;
                end
                SLOT_GREEN: begin
                    stage_green <= wd_comp;
                    byte_slot   <= SLOT_BLUE;
                end
                default: begin
                    pix_addr  <= ptr_next;
                    byte_slot <= SLOT_RED;
                end
            endcase
        end else if (color_rd) begin
            unique case (byte_slot)
                SLOT_RED:   byte_slot <= SLOT_GREEN;
                SLOT_GREEN: byte_slot <= SLOT_BLUE;
                default: begin
                    hold_q    <= ram_rdata;
                    pix_addr  <= ptr_next;
                    byte_slot <= SLOT_RED;
                end
            endcase
        end
    end

endmodule

// File: rtl/palette_host_ctrl.sv
// Module: palette_host_ctrl
// Host register port of the color lookup table. It decodes the select, holds
// the mask and mode registers, sequences color triples through the palette
// and registers the read data. It assumes synchronous single-cycle strobes,
// with the select valid while a strobe is high.
module palette_host_ctrl
    import palette_host_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int ADDR_W    = 8,
    parameter int COMP_W    = 6,
    parameter int ARM_COUNT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        host_sel,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic [DATA_W-1:0] pll_rdata,
    output logic              pll_wr,
    output logic              pll_rd,
    output logic              pll_param,
    output logic [DATA_W-1:0] cmd_mode,
    output logic [DATA_W-1:0] pix_mask
);
    localparam int WORD_W = 3 * COMP_W;
    localparam int PAD_W  = DATA_W - COMP_W;

    logic               hf_armed;
    logic               eff_wr;
    logic               eff_rd;
    host_hits_t         hits;
    logic               ram_we;
    logic [ADDR_W-1:0]  ram_waddr;
    logic [WORD_W-1:0]  ram_wdata;
    logic [ADDR_W-1:0]  ram_raddr;
    logic [WORD_W-1:0]  ram_rdata;
    logic [ADDR_W-1:0]  pix_addr;
    byte_slot_e         byte_slot;
    logic [COMP_W-1:0]  rd_comp;
    logic [DATA_W-1:0]  rd_mux;
    logic [DATA_W-1:0]  mask_q;
    logic [DATA_W-1:0]  mode_q;
    logic [DATA_W-1:0]  rdata_q;

    palette_hidden_flag #(.ARM_COUNT(ARM_COUNT)) u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .host_sel (host_sel),
        .acc_wr   (eff_wr),
        .acc_rd   (eff_rd),
        .armed    (hf_armed)
    );

    palette_sel_decode u_dec (
        .host_wr  (host_wr),
        .host_rd  (host_rd),
        .host_sel (host_sel),
        .redirect (hf_armed),
        .eff_wr   (eff_wr),
        .eff_rd   (eff_rd),
        .hits     (hits)
    );

    palette_rgb_seq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .COMP_W(COMP_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .ptr_load_w (hits.ptr_load_w),
        .ptr_load_r (hits.ptr_load_r),
        .color_wr   (hits.color_wr),
        .color_rd   (hits.color_rd),
        .wdata      (host_wdata),
        .ram_rdata  (ram_rdata),
        .ram_we     (ram_we),
        .ram_waddr  (ram_waddr),
        .ram_wdata  (ram_wdata),
        .ram_raddr  (ram_raddr),
        .pix_addr   (pix_addr),
        .byte_slot  (byte_slot),
        .rd_comp    (rd_comp)
    );

    palette_ram #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .waddr (ram_waddr),
        .wdata (ram_wdata),
        .raddr (ram_raddr),
        .rdata (ram_rdata)
    );

    // Select the byte a read returns.
    always_comb begin
        rd_mux = '0;
        if (hits.ptr_read)  rd_mux = DATA_W'(pix_addr);
        if (hits.color_rd)  rd_mux = {{PAD_W{1'b0}}, rd_comp};
        if (hits.mask_rd)   rd_mux = mask_q;
        if (hits.mode_rd)   rd_mux = mode_q;
        if (hits.clk_rd)    rd_mux = pll_rdata;
    end

    // Mask, mode and read-data registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q  <= '1;
            mode_q  <= '0;
            rdata_q <= '0;
        end else begin
            if (hits.mask_wr) mask_q  <= host_wdata;
            if (hits.mode_wr) mode_q  <= host_wdata;
            if (eff_rd)       rdata_q <= rd_mux;
        end
    end

    assign host_rdata = rdata_q;
    assign cmd_mode   = mode_q;
    assign pix_mask   = mask_q;
    assign pll_wr     = hits.clk_wr;
    assign pll_rd     = hits.clk_rd;
    assign pll_param  = hits.clk_param;

endmodule

// File: rtl/palette_host_ctrl_chk.sv
// Module: palette_host_ctrl_chk
// Property checker attached to palette_host_ctrl. It watches the host port,
// the pointer, the byte slot and the redirect flag.
module palette_host_ctrl_chk #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 8,
    parameter int COMP_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        host_sel,
    input logic              host_wr,
    input logic              host_rd,
    input logic [DATA_W-1:0] host_wdata,
    input logic [DATA_W-1:0] host_rdata,
    input logic [ADDR_W-1:0] pix_addr,
    input logic [1:0]        byte_slot,
    input logic              armed,
    input logic [DATA_W-1:0] cmd_mode,
    input logic              pll_wr
);
    // R4
    color_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_sel == 3'b001 && byte_slot == 2'd2)
        |=> (pix_addr == ADDR_W'($past(pix_addr) + 1'b1)));

    // R6
    ptr_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_sel == 3'b000)
        |=> (byte_slot == 2'd0 && pix_addr == $past(host_wdata[ADDR_W-1:0])));

    // R5
    prefetch_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_sel == 3'b011)
        |=> (byte_slot == 2'd0 && pix_addr == ADDR_W'($past(host_wdata[ADDR_W-1:0]) + 1'b1)));

    // R3
    color_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !host_wr && host_sel == 3'b001)
        |=> (host_rdata[DATA_W-1:COMP_W] == '0));

    // R3
    slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_slot != 2'd3);

    // R9
    mode_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_sel == 3'b110) |=> (cmd_mode == $past(host_wdata)));

    // R8
    flag_consume_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && (host_wr || host_rd) && host_sel == 3'b010) |=> !armed);

    // R10
    clk_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pll_wr |-> (host_wr && host_sel[2] && host_sel != 3'b110));

endmodule

bind palette_host_ctrl palette_host_ctrl_chk #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .COMP_W(COMP_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_sel   (host_sel),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .pix_addr   (pix_addr),
    .byte_slot  (byte_slot),
    .armed      (hf_armed),
    .cmd_mode   (cmd_mode),
    .pll_wr     (pll_wr)
);

// File: tb/palette_host_ctrl_bench.sv
// Bench for palette_host_ctrl: a vector table walk, then directed cases.
module palette_host_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 31;
    localparam logic [1:0] OP_W = 2'd1;
    localparam logic [1:0] OP_R = 2'd2;

    // {req[3:0], op[1:0], sel[2:0], data[7:0], expected[7:0]}
    localparam logic [24:0] VEC [NV] = '{
        {4'd4,  OP_W, 3'b000, 8'h10, 8'h00},  // R4 pointer 0x10
        {4'd4,  OP_W, 3'b001, 8'h01, 8'h00},
        {4'd4,  OP_W, 3'b001, 8'h02, 8'h00},
        {4'd4,  OP_W, 3'b001, 8'h03, 8'h00},
        {4'd3,  OP_W, 3'b001, 8'hC4, 8'h00},  // R3 bits 7:6 dropped
        {4'd3,  OP_W, 3'b001, 8'h05, 8'h00},
        {4'd3,  OP_W, 3'b001, 8'h06, 8'h00},
        {4'd4,  OP_W, 3'b001, 8'h3F, 8'h00},
        {4'd4,  OP_W, 3'b001, 8'h00, 8'h00},
        {4'd4,  OP_W, 3'b001, 8'h2A, 8'h00},
        {4'd2,  OP_R, 3'b000, 8'h00, 8'h13},  // R2 both pointer selects
        {4'd2,  OP_R, 3'b011, 8'h00, 8'h13},
        {4'd5,  OP_W, 3'b011, 8'h10, 8'h00},  // R5 prefetch entry 0x10
        {4'd3,  OP_R, 3'b001, 8'h00, 8'h01},
        {4'd3,  OP_R, 3'b001, 8'h00, 8'h02},
        {4'd5,  OP_R, 3'b001, 8'h00, 8'h03},
        {4'd3,  OP_R, 3'b001, 8'h00, 8'h04},
        {4'd5,  OP_R, 3'b001, 8'h00, 8'h05},
        {4'd5,  OP_R, 3'b001, 8'h00, 8'h06},
        {4'd5,  OP_R, 3'b001, 8'h00, 8'h3F},
        {4'd5,  OP_R, 3'b001, 8'h00, 8'h00},
        {4'd5,  OP_R, 3'b001, 8'h00, 8'h2A},
        {4'd5,  OP_R, 3'b000, 8'h00, 8'h14},  // R5 pointer after refetches
        {4'd7,  OP_W, 3'b010, 8'hF0, 8'h00},  // mask 0xF0
        {4'd7,  OP_R, 3'b010, 8'h00, 8'hF0},  // R7 arming reads
        {4'd7,  OP_R, 3'b010, 8'h00, 8'hF0},
        {4'd7,  OP_R, 3'b010, 8'h00, 8'hF0},
        {4'd7,  OP_R, 3'b010, 8'h00, 8'hF0},
        {4'd7,  OP_W, 3'b010, 8'h81, 8'h00},  // redirected to mode
        {4'd8,  OP_R, 3'b010, 8'h00, 8'hF0},  // R8 flag used up, mask kept
        {4'd9,  OP_R, 3'b110, 8'h00, 8'h81}   // R9 mode read direct
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] host_sel = '0;
    logic       host_wr = 1'b0;
    logic       host_rd = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic [7:0] pll_rdata = '0;
    logic       pll_wr;
    logic       pll_rd;
    logic       pll_param;
    logic [7:0] cmd_mode;
    logic [7:0] pix_mask;

    int n_vec = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    palette_host_ctrl u_palette_host_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_sel   (host_sel),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .pll_rdata  (pll_rdata),
        .pll_wr     (pll_wr),
        .pll_rd     (pll_rd),
        .pll_param  (pll_param),
        .cmd_mode   (cmd_mode),
        .pix_mask   (pix_mask)
    );

    task automatic check(input int req, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one access at a falling edge; return after the next falling edge.
    task automatic access(input logic [1:0] op, input logic [2:0] sel, input logic [7:0] d);
        host_sel   = sel;
        host_wdata = d;
        host_wr    = (op == OP_W);
        host_rd    = (op == OP_R);
        @(posedge clk);
        #1;
        host_wr = 1'b0;
        host_rd = 1'b0;
        @(negedge clk);
    endtask

    task automatic rd_check(input logic [2:0] sel, input logic [7:0] exp, input int req);
        access(OP_R, sel, 8'h00);
        check(req, host_rdata, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check(1, host_rdata, 8'h00);
        check(1, cmd_mode, 8'h00);
        check(1, pix_mask, 8'hFF);
        rd_check(3'b000, 8'h00, 1);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            access(VEC[i][20:19], VEC[i][18:16], VEC[i][15:8]);
            if (VEC[i][20:19] == OP_R) check(int'(VEC[i][24:21]), host_rdata, VEC[i][7:0]);
        end
        check(9, cmd_mode, 8'h81);  // R9 output follows mode register

        // R6 abort a write triple, then read the clean entry back
        access(OP_W, 3'b000, 8'h20);
        access(OP_W, 3'b001, 8'h11);
        access(OP_W, 3'b001, 8'h12);
        access(OP_W, 3'b000, 8'h20);
        access(OP_W, 3'b001, 8'h07);
        access(OP_W, 3'b001, 8'h08);
        access(OP_W, 3'b001, 8'h09);
        access(OP_W, 3'b011, 8'h20);
        rd_check(3'b001, 8'h07, 6);
        rd_check(3'b001, 8'h08, 6);
        rd_check(3'b001, 8'h09, 6);

        // R6 abort a read triple
        access(OP_W, 3'b011, 8'h10);
        rd_check(3'b001, 8'h01, 6);
        access(OP_W, 3'b011, 8'h11);
        rd_check(3'b001, 8'h04, 6);

        // R11 pointer wrap on blue write
        access(OP_W, 3'b000, 8'hFF);
        access(OP_W, 3'b001, 8'h01);
        access(OP_W, 3'b001, 8'h02);
        access(OP_W, 3'b001, 8'h03);
        rd_check(3'b000, 8'h00, 11);

        // R8 an access elsewhere breaks the run of mask reads
        rd_check(3'b010, 8'hF0, 8);
        rd_check(3'b010, 8'hF0, 8);
        rd_check(3'b010, 8'hF0, 8);
        rd_check(3'b000, 8'h00, 8);
        rd_check(3'b010, 8'hF0, 8);
        // R7 redirected read returns the mode register
        rd_check(3'b010, 8'hF0, 7);
        rd_check(3'b010, 8'hF0, 7);
        rd_check(3'b010, 8'hF0, 7);
        rd_check(3'b010, 8'h81, 7);
        rd_check(3'b010, 8'hF0, 8);
        check(7, pix_mask, 8'hF0);

        // R9 direct mode write
        access(OP_W, 3'b110, 8'h00);
        check(9, cmd_mode, 8'h00);

        // R10 clock-generator selects pass through
        pll_rdata  = 8'h5A;
        host_sel   = 3'b101;
        host_rd    = 1'b1;
        #1;
        check(10, {5'd0, pll_rd, pll_param, pll_wr}, 8'b0000_0110);
        @(posedge clk);
        #1;
        host_rd = 1'b0;
        check(10, host_rdata, 8'h5A);
        @(negedge clk);
        host_sel   = 3'b100;
        host_wdata = 8'h33;
        host_wr    = 1'b1;
        #1;
        check(10, {5'd0, pll_rd, pll_param, pll_wr}, 8'b0000_0001);
        @(posedge clk);
        #1;
        host_wr = 1'b0;
        @(negedge clk);
        rd_check(3'b000, 8'h00, 10);
        check(10, pix_mask, 8'hF0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule